// File: doc/BRIEF.md
# System Coprocessor Register Access Decoder

This block sits next to a processor pipeline and serves the instructions that target one system-control coprocessor. Each cycle it may receive one decoded coprocessor instruction. That instruction carries an instruction class, a coprocessor number, the four selector fields (first opcode, primary register number, secondary register number, second opcode), a direction bit, a privilege flag and write data. The block either completes a register transfer or raises an undefined-instruction trap. Instructions for any other coprocessor pass by untouched.

A read-only identification word sits at primary register 0. The second opcode selects either the device identity or a cache-type word there. Primary registers 1 to `NUM_CTRL` are writable 32-bit control words. Only privileged register transfers reach the register file. Every other instruction class traps, and so does any unprivileged access. Accesses that the register map leaves undefined do not change any state. Such an access reads back zero and raises a separate flag for the undefined access. Every accepted instruction gets a response one cycle later.

Top module: `sysco_access`

## Requirements
- R1: After a synchronous active-high reset, `rsp_done`, `rsp_trap`, `rsp_undef` and `rsp_rdata` are all zero. Control register n (1 ≤ n ≤ `NUM_CTRL`) then holds `CTRL_RST_BASE + n`.
- R2: A request whose `req_cpnum` differs from `CP_NUM` gives no response in the following cycle and changes no register.
- R3: `req_class` is encoded as 0 = register transfer, 1 = data processing, 2 = load, 3 = store. A class 1, 2 or 3 request for this coprocessor responds with `rsp_trap`=1 and `rsp_rdata`=0, whatever the privilege flag, and changes no register.
- R4: A register transfer with `req_priv`=0 responds with `rsp_trap`=1 and changes no register, whatever its fields hold.
- R5: Each request for this coprocessor gives `rsp_done`=1 in the cycle after it is presented. When `rsp_done` is 0, the signals `rsp_trap`, `rsp_undef` and `rsp_rdata` are all 0.
- R6: A privileged read (`req_dir_rd`=1) with primary register 0, first opcode 0, secondary register 0 and any second opcode other than 1 returns `DEVICE_ID`.
- R7: The same read with second opcode 1 returns `CACHE_TYPE`.
- R8: A privileged write (`req_dir_rd`=0) to primary register n in 1..`NUM_CTRL`, with first opcode, secondary register and second opcode all zero, stores `req_wdata` at the clock edge that accepts it. A read presented in the very next cycle returns that value. A read with the same field values returns the stored word.
- R9: A privileged write to primary register 0 responds with `rsp_undef`=1 and `rsp_rdata`=0, and leaves every register unchanged.
- R10: A privileged transfer that sets a nonzero first opcode or secondary register, or a nonzero second opcode for primary registers 1 and above, responds with `rsp_undef`=1 and `rsp_rdata`=0 and changes no register.
- R11: A privileged transfer to a primary register above `NUM_CTRL` responds with `rsp_undef`=1 and `rsp_rdata`=0 and changes no register.
- R12: `rsp_trap` and `rsp_undef` are never both 1, and a trap takes precedence over an undefined access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A coprocessor instruction is presented this cycle |
| req_class | input | 2 | Instruction class (0 transfer, 1 data processing, 2 load, 3 store) |
| req_cpnum | input | 4 | Target coprocessor number |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_op2 | input | 3 | Second opcode field |
| req_dir_rd | input | 1 | Direction: 1 reads from the coprocessor, 0 writes to it |
| req_priv | input | 1 | Issuing mode is privileged |
| req_wdata | input | 32 | Data for a write transfer |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_trap | output | 1 | Undefined-instruction trap, valid with `rsp_done` |
| rsp_undef | output | 1 | Access the register map leaves undefined, valid with `rsp_done` |
| rsp_rdata | output | 32 | Read data, valid with `rsp_done` |

## Verification
The hardest state to reach from the ports is a rejected write that would have changed a register. Examples are a write with a stray nonzero selector field, an unprivileged write, or a write in a trapping class. Such a write shows nothing at the moment it happens. The bench therefore keeps a shadow copy of every control register and reads each one back in later transfers. A random mix of classes, privilege and field values is interleaved with those reads, so a leaked write shows up as a read mismatch. Directed cases cover the edges of the identity page. Directed cases also cover a read issued in the cycle right after a write.

// File: rtl/sysco_pkg.sv
package sysco_pkg;

    typedef enum logic [1:0] {
        CLS_XFER  = 2'd0,
        CLS_DATA  = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_STORE = 2'd3
    } cp_class_e;

    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_TRAP  = 2'd1,
        VERD_UNDEF = 2'd2,
        VERD_OK    = 2'd3
    } verdict_e;

    typedef struct packed {
        cp_class_e  cls;
        logic [3:0] cpnum;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
        logic       dir_rd;
        logic       priv;
    } cp_req_t;

    typedef struct packed {
        verdict_e   verdict;
        logic       wr;
        logic       sel_ident;
        logic       sel_cache;
        logic [3:0] idx;
    } cp_dec_t;

    function automatic logic selectors_clear(input cp_req_t r, input logic need_op2);
        return (r.op1 == 3'd0) && (r.crm == 4'd0) && (!need_op2 || r.op2 == 3'd0);
    endfunction

endpackage

// File: rtl/sysco_decode.sv
module sysco_decode
    import sysco_pkg::*;
#(
    parameter int CP_NUM   = 15,
    parameter int NUM_CTRL = 3
) (
    input  logic    valid,
    input  cp_req_t req,
    output cp_dec_t dec
);
    localparam logic [3:0] CP_CODE  = 4'(CP_NUM);
    localparam logic [3:0] LAST_REG = 4'(NUM_CTRL);

    always_comb begin
        dec = '{verdict: VERD_NONE, wr: 1'b0, sel_ident: 1'b0,
                sel_cache: 1'b0, idx: req.crn};
        if (valid && req.cpnum == CP_CODE) begin
            if (req.cls != CLS_XFER || !req.priv) begin
                dec.verdict = VERD_TRAP;
            end else if (req.crn == 4'd0) begin
                if (req.dir_rd && selectors_clear(req, 1'b0)) begin
                    dec.verdict   = VERD_OK;
                    dec.sel_cache = (req.op2 == 3'd1);
                    dec.sel_ident = (req.op2 != 3'd1);
                end else begin
                    dec.verdict = VERD_UNDEF;
                end
            end else if (req.crn <= LAST_REG && selectors_clear(req, 1'b1)) begin
                dec.verdict = VERD_OK;
                dec.wr      = !req.dir_rd;
            end else begin
                dec.verdict = VERD_UNDEF;
            end
        end
    end

endmodule

// File: rtl/sysco_ctrl_regs.sv
module sysco_ctrl_regs #(
    parameter int          NUM_CTRL      = 3,
    parameter logic [31:0] CTRL_RST_BASE = 32'h0000_0070
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic [3:0]  rd_idx,
    output logic [31:0] rd_data
);
    logic [31:0] regs [1:NUM_CTRL];

    for (genvar g = 1; g <= NUM_CTRL; g++) begin : g_reg
        localparam logic [3:0]  MY_IDX = 4'(g);
        localparam logic [31:0] MY_RST = CTRL_RST_BASE + 32'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= MY_RST;
            end else if (wr_en && wr_idx == MY_IDX) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 1; i <= NUM_CTRL; i++) begin
            if (rd_idx == 4'(i)) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/sysco_access.sv
module sysco_access
    import sysco_pkg::*;
#(
    parameter int          CP_NUM        = 15,
    parameter int          NUM_CTRL      = 3,
    parameter logic [31:0] DEVICE_ID     = 32'h5C0D_1E01,
    parameter logic [31:0] CACHE_TYPE    = 32'h0D17_2152,
    parameter logic [31:0] CTRL_RST_BASE = 32'h0000_0070
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_class,
    input  logic [3:0]  req_cpnum,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic        req_dir_rd,
    input  logic        req_priv,
    input  logic [31:0] req_wdata,
    output logic        rsp_done,
    output logic        rsp_trap,
    output logic        rsp_undef,
    output logic [31:0] rsp_rdata
);
    cp_req_t     req;
    cp_dec_t     dec;
    logic [31:0] reg_rd;
    logic [31:0] rd_mux;

    assign req = '{cls: cp_class_e'(req_class), cpnum: req_cpnum, op1: req_op1,
                   crn: req_crn, crm: req_crm, op2: req_op2,
                   dir_rd: req_dir_rd, priv: req_priv};

    sysco_decode #(.CP_NUM(CP_NUM), .NUM_CTRL(NUM_CTRL)) u_decode (
        .valid (req_valid),
        .req   (req),
        .dec   (dec)
    );

    sysco_ctrl_regs #(.NUM_CTRL(NUM_CTRL), .CTRL_RST_BASE(CTRL_RST_BASE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dec.verdict == VERD_OK && dec.wr),
        .wr_idx  (dec.idx),
        .wr_data (req_wdata),
        .rd_idx  (dec.idx),
        .rd_data (reg_rd)
    );

    always_comb begin
        if (dec.verdict != VERD_OK || dec.wr) begin
            rd_mux = '0;
        end else if (dec.sel_ident) begin
            rd_mux = DEVICE_ID;
        end else if (dec.sel_cache) begin
            rd_mux = CACHE_TYPE;
        end else begin
            rd_mux = reg_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_trap  <= 1'b0;
            rsp_undef <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done  <= (dec.verdict != VERD_NONE);
            rsp_trap  <= (dec.verdict == VERD_TRAP);
            rsp_undef <= (dec.verdict == VERD_UNDEF);
            rsp_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/sysco_access_chk.sv
module sysco_access_chk #(
    parameter int          CP_NUM    = 15,
    parameter logic [31:0] DEVICE_ID = 32'h5C0D_1E01
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_class,
    input logic [3:0]  req_cpnum,
    input logic [2:0]  req_op1,
    input logic [3:0]  req_crn,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_op2,
    input logic        req_dir_rd,
    input logic        req_priv,
    input logic        rsp_done,
    input logic        rsp_trap,
    input logic        rsp_undef,
    input logic [31:0] rsp_rdata
);
    logic own;
    assign own = req_valid && (req_cpnum == 4'(CP_NUM));

    AST_DONE_AFTER_OWN: assert property (@(posedge clk) disable iff (rst)
        own |=> rsp_done); // R5

    AST_SILENT_FOREIGN: assert property (@(posedge clk) disable iff (rst)
        !own |=> !rsp_done); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_done |-> (!rsp_trap && !rsp_undef && rsp_rdata == 32'd0)); // R5

    AST_CLASS_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (own && req_class != 2'd0) |=> (rsp_trap && rsp_rdata == 32'd0)); // R3

    AST_UNPRIV_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (own && !req_priv) |=> rsp_trap); // R4

    AST_TRAP_UNDEF_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_trap && rsp_undef)); // R12

    AST_IDENT_READ: assert property (@(posedge clk) disable iff (rst)
        (own && req_class == 2'd0 && req_priv && req_dir_rd && req_crn == 4'd0 &&
         req_op1 == 3'd0 && req_crm == 4'd0 && req_op2 != 3'd1)
        |=> (rsp_rdata == DEVICE_ID)); // R6

    AST_ID_WRITE_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (own && req_class == 2'd0 && req_priv && !req_dir_rd && req_crn == 4'd0)
        |=> (rsp_undef && rsp_rdata == 32'd0)); // R9

endmodule

bind sysco_access sysco_access_chk #(.CP_NUM(CP_NUM), .DEVICE_ID(DEVICE_ID)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_class  (req_class),
    .req_cpnum  (req_cpnum),
    .req_op1    (req_op1),
    .req_crn    (req_crn),
    .req_crm    (req_crm),
    .req_op2    (req_op2),
    .req_dir_rd (req_dir_rd),
    .req_priv   (req_priv),
    .rsp_done   (rsp_done),
    .rsp_trap   (rsp_trap),
    .rsp_undef  (rsp_undef),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/sysco_access_tb.sv
module sysco_access_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          CP_NUM     = 15;
    localparam int          NUM_CTRL   = 3;
    localparam logic [31:0] DEV_ID     = 32'h5C0D_1E01;
    localparam logic [31:0] CACHE_W    = 32'h0D17_2152;
    localparam logic [31:0] RST_BASE   = 32'h0000_0070;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_class = '0;
    logic [3:0]  req_cpnum = '0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic        req_dir_rd = 1'b0;
    logic        req_priv = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done, rsp_trap, rsp_undef;
    logic [31:0] rsp_rdata;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;
    logic [31:0] shadow [1:NUM_CTRL];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sysco_access #(
        .CP_NUM(CP_NUM), .NUM_CTRL(NUM_CTRL), .DEVICE_ID(DEV_ID),
        .CACHE_TYPE(CACHE_W), .CTRL_RST_BASE(RST_BASE)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .req_cpnum(req_cpnum), .req_op1(req_op1), .req_crn(req_crn),
        .req_crm(req_crm), .req_op2(req_op2), .req_dir_rd(req_dir_rd),
        .req_priv(req_priv), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_trap(rsp_trap), .rsp_undef(rsp_undef), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [35:0] act,
                         input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent model of the response; updates the shadow registers on accepted writes.
    task automatic model(input logic [1:0] cls, input logic [3:0] cp, input logic [2:0] o1,
                         input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] o2,
                         input logic rd, input logic pv, input logic [31:0] wd,
                         output logic e_done, output logic e_trap, output logic e_undef,
                         output logic [31:0] e_data, output string tag);
        e_done = 1'b0; e_trap = 1'b0; e_undef = 1'b0; e_data = '0;
        if (cp != 4'(CP_NUM)) begin
            tag = "R2";
        end else begin
            e_done = 1'b1;
            if (cls != 2'd0) begin
                e_trap = 1'b1; tag = "R3";
            end else if (!pv) begin
                e_trap = 1'b1; tag = "R4";
            end else if (crn == 4'd0) begin
                if (!rd) begin
                    e_undef = 1'b1; tag = "R9";
                end else if (o1 != 0 || crm != 0) begin
                    e_undef = 1'b1; tag = "R10";
                end else if (o2 == 3'd1) begin
                    e_data = CACHE_W; tag = "R7";
                end else begin
                    e_data = DEV_ID; tag = "R6";
                end
            end else if (crn > 4'(NUM_CTRL)) begin
                e_undef = 1'b1; tag = "R11";
            end else if (o1 != 0 || crm != 0 || o2 != 0) begin
                e_undef = 1'b1; tag = "R10";
            end else if (rd) begin
                e_data = shadow[int'(crn)]; tag = "R8";
            end else begin
                shadow[int'(crn)] = wd; tag = "R8";
            end
        end
    endtask

    // Drive at a falling edge, response appears after the next rising edge;
    // sample it at the following falling edge.
    task automatic access(input logic [1:0] cls, input logic [3:0] cp, input logic [2:0] o1,
                          input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] o2,
                          input logic rd, input logic pv, input logic [31:0] wd);
        logic e_done, e_trap, e_undef;
        logic [31:0] e_data;
        string tag;
        req_valid = 1'b1; req_class = cls; req_cpnum = cp; req_op1 = o1;
        req_crn = crn; req_crm = crm; req_op2 = o2; req_dir_rd = rd;
        req_priv = pv; req_wdata = wd;
        model(cls, cp, o1, crn, crm, o2, rd, pv, wd, e_done, e_trap, e_undef, e_data, tag);
        @(negedge clk);
        check(rsp_done == e_done, {tag, " done"}, 36'(rsp_done), 36'(e_done));
        check(rsp_trap == e_trap, {tag, " trap"}, 36'(rsp_trap), 36'(e_trap));
        check(rsp_undef == e_undef, {tag, " undef R12"}, 36'(rsp_undef), 36'(e_undef));
        check(rsp_rdata == e_data, {tag, " rdata"}, 36'(rsp_rdata), 36'(e_data));
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        @(negedge clk);
        check(!rsp_done && !rsp_trap && !rsp_undef && rsp_rdata == 0, "R5 idle",
              {rsp_done, rsp_trap, rsp_undef, 1'b0, rsp_rdata}, 36'd0);
    endtask

    task automatic read_all_regs();
        for (int i = 1; i <= NUM_CTRL; i++)
            access(2'd0, 4'(CP_NUM), 3'd0, 4'(i), 4'd0, 3'd0, 1'b1, 1'b1, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 1; i <= NUM_CTRL; i++) shadow[i] = RST_BASE + 32'(i);
        repeat (3) @(negedge clk);
        // R1: outputs quiet while and after reset
        check(!rsp_done && !rsp_trap && !rsp_undef && rsp_rdata == 0, "R1 reset outputs",
              {rsp_done, rsp_trap, rsp_undef, 1'b0, rsp_rdata}, 36'd0);
        rst = 1'b0;
        @(negedge clk);
        read_all_regs();   // R1 reset values
        idle_check();

        // R6/R7 identity page, all second-opcode values
        for (int k = 0; k < 8; k++)
            access(2'd0, 4'(CP_NUM), 3'd0, 4'd0, 4'd0, 3'(k), 1'b1, 1'b1, 32'd0);
        // R8 write then read in the next cycle
        access(2'd0, 4'(CP_NUM), 3'd0, 4'd2, 4'd0, 3'd0, 1'b0, 1'b1, 32'hA5A5_0F0F);
        access(2'd0, 4'(CP_NUM), 3'd0, 4'd2, 4'd0, 3'd0, 1'b1, 1'b1, 32'd0);
        // R9 write to the identity register
        access(2'd0, 4'(CP_NUM), 3'd0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b1, 32'hFFFF_FFFF);
        // R10 stray selectors on a write, R4 unprivileged write, R3 load class
        access(2'd0, 4'(CP_NUM), 3'd1, 4'd1, 4'd0, 3'd0, 1'b0, 1'b1, 32'h1111_1111);
        access(2'd0, 4'(CP_NUM), 3'd0, 4'd1, 4'd2, 3'd0, 1'b0, 1'b1, 32'h2222_2222);
        access(2'd0, 4'(CP_NUM), 3'd0, 4'd3, 4'd0, 3'd4, 1'b0, 1'b1, 32'h3333_3333);
        access(2'd0, 4'(CP_NUM), 3'd0, 4'd1, 4'd0, 3'd0, 1'b0, 1'b0, 32'h4444_4444);
        access(2'd2, 4'(CP_NUM), 3'd0, 4'd1, 4'd0, 3'd0, 1'b0, 1'b1, 32'h5555_5555);
        // R11 beyond the last control register, R2 foreign coprocessor write
        access(2'd0, 4'(CP_NUM), 3'd0, 4'(NUM_CTRL + 1), 4'd0, 3'd0, 1'b1, 1'b1, 32'd0);
        access(2'd0, 4'd14, 3'd0, 4'd1, 4'd0, 3'd0, 1'b0, 1'b1, 32'h6666_6666);
        idle_check();
        read_all_regs();   // confirm that no rejected write leaked

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [1:0] cls;
            logic [3:0] cp;
            cls = ($urandom_range(0, 9) < 7) ? 2'd0 : 2'($urandom_range(1, 3));
            cp  = ($urandom_range(0, 9) < 8) ? 4'(CP_NUM) : 4'($urandom_range(0, 14));
            access(cls, cp,
                   ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0,
                   4'($urandom_range(0, NUM_CTRL + 2)),
                   ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'd0,
                   ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0,
                   1'($urandom), ($urandom_range(0, 9) < 8), $urandom);
            if (n % 50 == 49) idle_check();
        end
        idle_check();
        read_all_regs();
        idle_check();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule